// File: doc/BRIEF.md
# Level-Sensitive RAM Write Strobe Generator

This block drives the write-enable line of a RAM that stores data for as long as its write line is high, not on an edge. A memory write lasts two control states in a row. During both of them the block raises a hold output, which tells the surrounding datapath to leave the RAM address and write data alone. The strobe itself comes from a flip-flop clocked on the falling system clock edge. It therefore rises half a cycle after the address and data become valid, and it falls half a cycle before they are free to change again.

The datapath asks for a write by raising a request level ahead of a rising edge. It loads the address and data on that same edge. Requests that arrive while a write is in progress are not queued. A request that is still high when the sequence ends starts a fresh write.

Top module: `ram_wstrobe_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and right after it is released, both wr_en and hold are low.
- R2: With the block idle, a high wr_req sampled at a rising clock edge makes hold go high at that edge.
- R3: Once hold rises it stays high for exactly two clock periods and then falls at the following rising edge.
- R4: wr_en rises at the falling clock edge inside the first hold period.
- R5: wr_en falls at the falling clock edge inside the second hold period, so it stays high for exactly one clock period.
- R6: wr_en is never high unless hold is high.
- R7: wr_req is ignored while hold is high. A request held high without a break produces write sequences separated by exactly one clock period with hold low.
- R8: With wr_req low, the block stays idle: hold and wr_en remain low.
- R9: An asynchronous reset during a write sequence drives wr_en and hold low at once, and the block stays idle until a new request arrives.
- R10: A datapath that updates address and data only on rising edges where hold is low never changes them while wr_en is high, and the RAM ends up holding the requested data at the requested address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the state changes on the rising edge and the strobe flop on the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Control request to perform a memory write |
| wr_en | output | 1 | Level-sensitive RAM write enable, active high |
| hold | output | 1 | High while address and write data must stay constant |

## Verification
On every rising edge, the assertions check how the strobe sits inside the hold window. The strobe is never high outside hold. By the end of the first write state it has been raised, and by the end of the second it has been dropped. The hold window lasts exactly two periods. Three things can only be seen in the bench scenarios: the half-cycle placement of the strobe edges relative to the falling clock, the effect of a reset in the middle of a write, and whether a datapath built around hold actually keeps address and data still while the strobe is high and lands the right word in the RAM.

// File: rtl/ram_wstrobe_gen.sv
module ram_wstrobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  output logic wr_en,
  output logic hold
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_W1 = 2'd1, S_W2 = 2'd2} wst_t;

  wst_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  st <= wr_req ? S_W1 : S_IDLE;
        S_W1:    st <= S_W2;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hold = (st != S_IDLE);

  // strobe flop on the inverted clock: high from mid-W1 to mid-W2
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wr_en <= 1'b0;
    else        wr_en <= (st == S_W1);
  end

  assert_en_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> hold);

  assert_en_up_in_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> wr_en);

  assert_en_down_in_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> !wr_en);

  assert_hold_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |=> hold);

  assert_hold_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |=> !hold);

endmodule

// File: tb/sim_ram_wstrobe_gen.sv
module sim_ram_wstrobe_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic wr_en, hold;

  int n_chk = 0;
  int n_bad = 0;
  int glitches = 0;
  int en_rises = 0;

  logic [7:0]  nxt_addr = 8'h00;
  logic [15:0] nxt_data = 16'h0000;
  logic [7:0]  addr_q;
  logic [15:0] data_q;
  logic [15:0] ram [0:255];

  ram_wstrobe_gen u0 (.clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_en(wr_en), .hold(hold));

  always #(PERIOD/2) clk = ~clk;

  // datapath registers that respect hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin addr_q <= 8'h00; data_q <= 16'h0000; end
    else if (!hold) begin addr_q <= nxt_addr; data_q <= nxt_data; end
  end

  // level-sensitive RAM model
  always @(wr_en or addr_q or data_q) if (wr_en) ram[addr_q] = data_q;

  always @(addr_q or data_q) if (wr_en) glitches++;
  always @(posedge wr_en) en_rises++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic after_rise(); @(posedge clk); #(PERIOD/4); endtask
  task automatic after_fall(); @(negedge clk); #(PERIOD/4); endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #(PERIOD*2);
    check("R1 wr_en in reset", wr_en, 0);
    check("R1 hold in reset", hold, 0);
    @(negedge clk); rst_n = 1'b1;
    after_rise();
    check("R1 wr_en after release", wr_en, 0);
    check("R1 hold after release", hold, 0);
  endtask

  task automatic t_idle();
    wr_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      after_rise();
      check("R8 hold idle", hold, 0);
      check("R8 wr_en idle", wr_en, 0);
    end
  endtask

  task automatic t_single(input logic [7:0] a, input logic [15:0] d);
    nxt_addr = a; nxt_data = d; wr_req = 1'b1;
    after_rise();
    wr_req = 1'b0;
    check("R2 hold rises", hold, 1);
    check("R4 wr_en low before fall", wr_en, 0);
    after_fall();
    check("R4 wr_en up mid first", wr_en, 1);
    nxt_addr = ~a; nxt_data = ~d;
    after_rise();
    check("R3 hold second period", hold, 1);
    check("R5 wr_en still high", wr_en, 1);
    after_fall();
    check("R5 wr_en down mid second", wr_en, 0);
    check("R3 hold still high", hold, 1);
    after_rise();
    check("R3 hold falls", hold, 0);
    check("R6 wr_en low outside hold", wr_en, 0);
    check("R10 ram word", ram[a], d);
  endtask

  task automatic t_held_request();
    int r0;
    r0 = en_rises;
    nxt_addr = 8'h40; nxt_data = 16'h1111;
    wr_req = 1'b1;
    after_rise(); check("R7 seq1 start", hold, 1);
    after_rise(); check("R7 ignored in W1", hold, 1);
    after_rise(); check("R7 gap idle", hold, 0);
    nxt_addr = 8'h41; nxt_data = 16'h2222;
    after_rise(); check("R7 seq2 start", hold, 1);
    wr_req = 1'b0;
    after_rise(); check("R7 seq2 second", hold, 1);
    after_rise(); check("R7 seq2 done", hold, 0);
    after_rise(); check("R7 stays idle", hold, 0);
    check("R7 strobe count", en_rises - r0, 2);
    check("R10 ram first", ram[8'h40], 16'h1111);
    check("R10 ram second", ram[8'h41], 16'h2222);
  endtask

  task automatic t_reset_mid();
    nxt_addr = 8'h77; nxt_data = 16'h5A5A;
    wr_req = 1'b1;
    after_rise(); wr_req = 1'b0;
    after_fall();
    check("R9 strobe up before reset", wr_en, 1);
    rst_n = 1'b0;
    #1;
    check("R9 wr_en cleared", wr_en, 0);
    check("R9 hold cleared", hold, 0);
    @(negedge clk); rst_n = 1'b1;
    after_rise(); check("R9 idle after reset", hold, 0);
    after_fall(); check("R9 no strobe after reset", wr_en, 0);
  endtask

  initial begin : watchdog
    #(PERIOD*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_single(8'h12, 16'hBEEF);
    t_single(8'hFF, 16'h0001);
    t_held_request();
    t_reset_mid();
    t_single(8'h00, 16'hCAFE);
    check("R10 no change under strobe", glitches, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule